// File: doc/BRIEF.md
# Clocked Serial Bus Command Frame Transmitter

This block turns one host request into a master command frame and shifts it out on a single-wire, clocked serial bus. It builds three kinds of command. The first is an absolute-address access, either a read or a write of 1, 2 or 4 bytes. The second is a data-poll. The third is a terminate. The bus is active low and clocked by the master. The block drives a bus clock, a data line and an output enable for that data line. It appends a 4-bit CRC, which it computes serially while it shifts the frame out.

The host presents a request with `reqValid`. A request is taken only while the block is idle. `busy` then covers the whole frame, and a single-cycle `done` marks its end. The block does not receive responses, retry or control any level translator.

Top module: `cmdframe_tx`

## Requirements
- R1: Every frame opens with a start bit of logical 1, followed by the 2-bit slave id, most significant bit first. While idle, the bus clock is high, the data line is high and the output enable is low.
- R2: For `reqCmd` = 0 (access), the start bit and id are followed by the 3-bit code 100. Next comes one bit that is 1 for a read and 0 for a write (`reqWrite`=1 means write). Then come the 21-bit address, MSB first, and a 1-bit size flag.
- R3: `reqSize` selects the transfer size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A 1-byte access sends the address unchanged with size flag 0. A 2-byte access sends address bit 0 as 0 with flag 1. A 4-byte access sends address bits 1:0 as 01 with flag 1.
- R4: A write sends the data bytes after the size flag: 1, 2 or 4 bytes, MSB first within each byte. The first byte sent is `reqData[7:0]`, then `reqData[15:8]`, and so on. A read sends no data bits.
- R5: `reqCmd` = 1 sends a data-poll, which is start bit, id and the code 010. `reqCmd` = 2 or 3 sends a terminate, which is start bit, id and the code 111111.
- R6: Four CRC bits close every frame, sent from the most significant bit down. They are the x^4+x+1 CRC, with the register starting at zero, over the start bit and all frame bits.
- R7: The line is inverted. A logical 1 is driven as a low level on `busData`, and a logical 0 as a high level.
- R8: Each bit takes two clock cycles. In the first, the bus clock is low. In the second, it is high. The data line holds the same value across both cycles.
- R9: `busy` rises in the cycle after acceptance and stays high for exactly 2×N cycles, where N is the number of bits including start and CRC. `done` is high for one cycle right after. A request is accepted only when both `busy` and `done` are low, so `reqValid` during a frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqCmd | input | 2 | 0 access, 1 data-poll, 2/3 terminate |
| reqId | input | 2 | Slave id |
| reqAddr | input | 21 | Byte address for access |
| reqSize | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqData | input | 32 | Write data, byte 0 in bits 7:0 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| busClk | output | 1 | Bus clock, idles high |
| busData | output | 1 | Bus data line, active low |
| busOe | output | 1 | Data line output enable |

## Verification
The assertions take for granted that reset is held low for at least one clock edge, and that the request fields are stable in the cycle in which `reqValid` is sampled in the idle state. The bench changes inputs only on the falling edge of the system clock. It raises `reqValid` for one cycle for each frame it expects. To exercise the rule that a request during a frame has no effect, it deliberately raises `reqValid` with altered fields while `busy` is high. The scoreboard then shows that no such request leaks into the frame or starts a second one.

// File: rtl/cmdframe_pkg.sv
package cmdframe_pkg;
  localparam int ID_W       = 2;
  localparam int ADDR_W     = 21;
  localparam int DATA_BYTES = 4;
  localparam int DATA_W     = 8 * DATA_BYTES;
  localparam int CRC_W      = 4;
  localparam int FRAME_W    = 64;
  localparam int CNT_W      = 7;
  // start + id + code(3) + rw + addr + size flag
  localparam int HDR_W      = 1 + ID_W + 3 + 1 + ADDR_W + 1;
  localparam int PAD_W      = FRAME_W - HDR_W - DATA_W;

  typedef enum logic [1:0] {
    CMD_ACCESS = 2'd0,
    CMD_POLL   = 2'd1,
    CMD_TERM   = 2'd2,
    CMD_TERM2  = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic useCrc;
  } txStrobe_t;

  // serial CRC step, polynomial x^4 + x + 1
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[2], c[1], c[0] ^ fb, fb};
  endfunction
endpackage

// File: rtl/cmdframe_build.sv
module cmdframe_build
  import cmdframe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [1:0]        reqCmd,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqData,
  output logic              lineBit,
  output logic [CNT_W-1:0]  frameBits
);
  logic [FRAME_W-1:0] shiftReg, frameNext;
  logic [CRC_W-1:0]   crcReg;
  logic [CNT_W-1:0]   lenNext, dataBits;
  logic [ADDR_W-1:0]  addrAdj;
  logic               sizeFlag;
  logic [DATA_W-1:0]  dataSer;
  logic [HDR_W-1:0]   header;

  always_comb begin
    unique case (reqSize)
      2'd0: begin addrAdj = reqAddr;                    sizeFlag = 1'b0; dataBits = CNT_W'(8);  end
      2'd1: begin addrAdj = {reqAddr[ADDR_W-1:1], 1'b0};  sizeFlag = 1'b1; dataBits = CNT_W'(16); end
      default: begin addrAdj = {reqAddr[ADDR_W-1:2], 2'b01}; sizeFlag = 1'b1; dataBits = CNT_W'(32); end
    endcase
    for (int b = 0; b < DATA_BYTES; b++)
      dataSer[DATA_W-1-8*b -: 8] = reqData[8*b +: 8];
    header = {1'b1, reqId, 3'd4, ~reqWrite, addrAdj, sizeFlag};
    frameNext = '0;
    unique case (cmdKind_e'(reqCmd))
      CMD_ACCESS: begin
        frameNext = {header, dataSer, {PAD_W{1'b0}}};
        lenNext   = CNT_W'(HDR_W) + (reqWrite ? dataBits : '0);
      end
      CMD_POLL: begin
        frameNext[FRAME_W-1 -: 6] = {1'b1, reqId, 3'd2};
        lenNext = CNT_W'(6);
      end
      default: begin
        frameNext[FRAME_W-1 -: 9] = {1'b1, reqId, 6'h3F};
        lenNext = CNT_W'(9);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      crcReg    <= '0;
      frameBits <= '0;
    end else if (strobe.load) begin
      shiftReg  <= frameNext;
      crcReg    <= '0;
      frameBits <= lenNext;
    end else if (strobe.advance) begin
      if (strobe.useCrc) begin
        crcReg <= {crcReg[CRC_W-2:0], 1'b0};
      end else begin
        crcReg   <= crcStep(crcReg, shiftReg[FRAME_W-1]);
        shiftReg <= {shiftReg[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign lineBit = strobe.useCrc ? crcReg[CRC_W-1] : shiftReg[FRAME_W-1];
endmodule

// File: rtl/cmdframe_ctrl.sv
module cmdframe_ctrl
  import cmdframe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] frameBits,
  output txStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             clkLow
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_FIN} state_e;
  localparam logic [CNT_W-1:0] CRC_LAST = CNT_W'(CRC_W - 1);

  state_e           state;
  logic             phase;
  logic [CNT_W-1:0] bitCnt;
  logic             lastBit;

  assign lastBit        = (bitCnt == frameBits + CRC_LAST);
  assign strobe.load    = (state == ST_IDLE) && reqValid;
  assign strobe.advance = (state == ST_SEND) && phase;
  assign strobe.useCrc  = (bitCnt >= frameBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= 1'b0;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state  <= ST_SEND;
          phase  <= 1'b0;
          bitCnt <= '0;
        end
        ST_SEND: begin
          phase <= ~phase;
          if (phase) begin
            if (lastBit) state <= ST_FIN;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state == ST_SEND);
  assign done   = (state == ST_FIN);
  assign clkLow = busy && !phase;
endmodule

// File: rtl/cmdframe_tx.sv
module cmdframe_tx
  import cmdframe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqCmd,
  input  logic [1:0]  reqId,
  input  logic [20:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic        reqWrite,
  input  logic [31:0] reqData,
  output logic        busy,
  output logic        done,
  output logic        busClk,
  output logic        busData,
  output logic        busOe
);
  txStrobe_t        strobe;
  logic             lineBit, clkLow;
  logic [CNT_W-1:0] frameBits;

  cmdframe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .frameBits(frameBits),
    .strobe(strobe), .busy(busy), .done(done), .clkLow(clkLow)
  );

  cmdframe_build u_build (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqCmd(reqCmd), .reqId(reqId),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWrite(reqWrite), .reqData(reqData),
    .lineBit(lineBit), .frameBits(frameBits)
  );

  assign busClk  = ~clkLow;
  assign busData = busy ? ~lineBit : 1'b1;
  assign busOe   = busy;
endmodule

// File: rtl/cmdframe_chk.sv
module cmdframe_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic done,
  input logic busClk,
  input logic busData,
  input logic busOe
);
  // R1: idle line levels
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> (busClk && busData));
  // R8: data held through the high clock phase
  a_r8_data_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && busClk) |-> $stable(busData));
  // R8: a low clock phase is followed by a high one
  a_r8_clock_alt: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !busClk) |=> (busClk && busOe));
  // R9: frame only starts from a request
  a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));
  // R9: done follows the end of busy
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R9: done is a single-cycle pulse with busy low
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R9: the enable only during a frame
  a_r9_oe_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (busy && !done));
endmodule

bind cmdframe_tx cmdframe_chk u_chk (.*);

// File: tb/sim_cmdframe_tx.sv
`timescale 1ns/1ps
module sim_cmdframe_tx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqCmd = '0;
  logic [1:0]  reqId = '0;
  logic [20:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqData = '0;
  logic busy, done, busClk, busData, busOe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic expBit[$];
  int   expTag[$];
  logic frmBit[$];
  int   frmTag[$];
  logic prevClk = 1'b1;

  always #2.5 clk = ~clk;

  cmdframe_tx u0 (.*);

  function automatic string tagName(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic addField(input logic [31:0] v, input int w, input int tag);
    for (int i = w - 1; i >= 0; i--) begin
      frmBit.push_back(v[i]);
      frmTag.push_back(tag);
    end
  endtask

  // monitor: one bit per rising bus clock, compared against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (busOe && busClk && !prevClk) begin
        if (expBit.size() == 0) begin
          check(1'b0, "R9", "unexpected bit", 1, 0);
        end else begin
          logic e;
          int t;
          e = expBit.pop_front();
          t = expTag.pop_front();
          check((~busData) == e, tagName(t), "frame bit", int'(~busData), int'(e));
        end
      end
      prevClk = busClk;
    end
  end

  // driver: compute the expected frame, push it, issue the request, time it
  task automatic sendReq(input logic [1:0] cmd, input logic [1:0] id, input logic [20:0] addr,
                         input logic [1:0] size, input logic wr, input logic [31:0] data,
                         input bit spam);
    logic [3:0] c;
    logic [20:0] a;
    int nBytes, n, cnt;
    frmBit.delete();
    frmTag.delete();
    addField(1, 1, 1);               // R1 start bit
    addField(32'(id), 2, 1);         // R1 slave id
    if (cmd == 2'd0) begin
      nBytes = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
      a = (nBytes == 1) ? addr : (nBytes == 2) ? (addr & ~21'd1) : ((addr & ~21'd3) | 21'd1);
      addField(32'd4, 3, 2);         // R2 access code
      addField(32'(!wr), 1, 2);      // R2 read flag
      addField(32'(a), 21, 3);       // R3 folded address
      addField(32'(nBytes > 1), 1, 3);
      if (wr) for (int k = 0; k < nBytes; k++) addField(32'(data[8*k +: 8]), 8, 4); // R4
    end else if (cmd == 2'd1) begin
      addField(32'd2, 3, 5);         // R5 poll
    end else begin
      addField(32'h3F, 6, 5);        // R5 terminate
    end
    c = 4'd0;
    foreach (frmBit[i]) begin
      logic fb;
      fb = c[3] ^ frmBit[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
    end
    addField(32'(c), 4, 6);          // R6 CRC
    n = frmBit.size();
    foreach (frmBit[i]) begin
      expBit.push_back(frmBit[i]);
      expTag.push_back(frmTag[i]);
    end

    @(negedge clk);
    reqCmd = cmd; reqId = id; reqAddr = addr; reqSize = size; reqWrite = wr; reqData = data;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", int'(busy), 1);
    check(busClk == 1'b0, "R8", "first phase clock low", int'(busClk), 0);
    check(busData == 1'b0, "R7", "start bit drives low", int'(busData), 0);
    cnt = 0;
    while (busy === 1'b1 && cnt < 1000) begin
      cnt++;
      if (spam && cnt < 8) begin
        reqValid = 1'b1; reqId = ~id; reqCmd = 2'd3; reqAddr = ~addr;
      end else begin
        reqValid = 1'b0;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(cnt == 2 * n, "R9", "busy length", cnt, 2 * n);
    check(done == 1'b1, "R9", "done after frame", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9", "done single pulse / no second frame",
          int'({done, busy}), 0);
    check(expBit.size() == 0, "R9", "all frame bits seen", expBit.size(), 0);
    check(busClk && busData && !busOe, "R1", "idle after frame", int'({busClk, busData, busOe}), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busClk && busData && !busOe, "R1", "idle levels in reset", int'({busClk, busData, busOe}), 6);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R9", "reset state", int'({busy, done}), 0);
    check(busClk && busData && !busOe, "R1", "idle levels after reset", int'({busClk, busData, busOe}), 6);
    sendReq(2'd0, 2'd1, 21'h12345, 2'd0, 1'b0, 32'h0, 0);          // R2 read 1 byte
    sendReq(2'd0, 2'd2, 21'h0ABCD, 2'd1, 1'b0, 32'h0, 0);          // R3 2-byte, odd addr
    sendReq(2'd0, 2'd3, 21'h1FFFE, 2'd2, 1'b0, 32'h0, 0);          // R3 4-byte fold
    sendReq(2'd0, 2'd0, 21'h00007, 2'd0, 1'b1, 32'h000000A5, 0);   // R4 write 1 byte
    sendReq(2'd0, 2'd1, 21'h10001, 2'd1, 1'b1, 32'h0000C33C, 0);   // R4 write 2 bytes
    sendReq(2'd0, 2'd2, 21'h1FFFF, 2'd2, 1'b1, 32'hA1B2C3D4, 1);   // R4 write 4 bytes + R9 ignore
    sendReq(2'd0, 2'd3, 21'h0F0F2, 2'd3, 1'b1, 32'hFFFFFFFF, 0);   // R3 size code 3
    sendReq(2'd1, 2'd2, 21'h0, 2'd0, 1'b0, 32'h0, 0);              // R5 poll
    sendReq(2'd2, 2'd1, 21'h0, 2'd0, 1'b0, 32'h0, 1);              // R5 terminate
    sendReq(2'd3, 2'd3, 21'h0, 2'd0, 1'b0, 32'h0, 0);              // R5 terminate alt code
    sendReq(2'd1, 2'd0, 21'h0, 2'd0, 1'b0, 32'h0, 0);              // R6 CRC with id 0
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule